// File: doc/BRIEF.md
# Two-level page table walker

This block resolves a translation miss by walking a two-level translation table held in memory. It takes a 32-bit virtual address and an access direction, which is read or write. It then issues at most two 32-bit reads on a simple read port. The first read fetches a directory entry and the second fetches a page table entry. The walk ends with one of two results:

- a physical address together with the entry's permission and cache-attribute bits;
- a fault, classified as a page fault or a bus error.

The walker handles one request at a time. While a walk is in progress it holds `busy` high and ignores any new request. Each walk ends with a single-cycle result pulse. The pulse carries the faulting virtual address and the access direction, so the requester can report the fault.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to `dir_base + 4*vaddr[31:22]`.
- R2: The directory entry supplies the table base in bits 31:12, and its bits 11:1 are ignored. The second read goes to `{entry[31:12],12'h000} + 4*vaddr[21:12]`.
- R3: A directory entry with bit 0 clear ends the walk as a page fault (kind 1), and no second read is issued.
- R4: A page table entry with bit 0 clear ends the walk as a page fault (kind 1).
- R5: On success (kind 0), the physical address is `{pte[31:12], vaddr[11:0]}`. The attribute output carries `pte[8:1]`: bit 0 is readable, bit 1 is writable, bit 2 is the cache override and bits 7:3 are the cache attributes.
- R6: A write needs bit 2 of the page table entry and a read needs bit 1. If the needed bit is clear, the result is a page fault (kind 1).
- R7: A read answered with `mem_rerr` at either level ends the walk as a bus error (kind 2), whatever the returned data. No further read follows.
- R8: Every result reports the request's virtual address on `rsp_vaddr` and its direction on `rsp_write` (1 = write).
- R9: A request is accepted only while `busy` is low. `busy` stays high from acceptance until the result, and requests made while it is high have no effect.
- R10: `mem_rd` holds its address stable until `mem_rvalid` answers it.
- R11: `rsp_valid` is a one-cycle pulse, and `rsp_kind` is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Directory table base address |
| req_valid | input | 1 | Walk request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access direction, 1 = write |
| busy | output | 1 | Walk in progress |
| mem_rd | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response error |
| rsp_valid | output | 1 | Result pulse |
| rsp_kind | output | 2 | 0 ok, 1 page fault, 2 bus error |
| rsp_vaddr | output | 32 | Virtual address of the result |
| rsp_write | output | 1 | Direction of the result |
| rsp_paddr | output | 32 | Physical address (kind 0) |
| rsp_attr | output | 8 | pte[8:1] (kind 0) |

## Verification
The assertions check these rules on every cycle:
- the request/busy handshake;
- that a read address stays stable while it is unanswered;
- the first directory address after acceptance;
- that the page offset is preserved on success;
- the shape of the result pulse.

Some behaviours can only be shown by the bench's scenarios against its own memory model. These are the fault classification across the two levels, the permission checks, the number of reads issued in each case, and the second-level address built from an entry with junk low bits. The bench also covers response latencies from zero to three cycles and requests that arrive during a walk.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dir_base,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  output logic        busy,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rerr,
  output logic        rsp_valid,
  output logic [1:0]  rsp_kind,
  output logic [31:0] rsp_vaddr,
  output logic        rsp_write,
  output logic [31:0] rsp_paddr,
  output logic [7:0]  rsp_attr
);
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam logic [1:0] K_OK = 2'd0, K_PF = 2'd1, K_BUS = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL} st_t;
  st_t st;
  logic [31:0] va;
  logic        wr;
  logic [31-OFF_W:0] tbase;
  logic        fin;
  logic [1:0]  kind;

  wire hit     = mem_rd && mem_rvalid;
  wire perm_ok = wr ? mem_rdata[2] : mem_rdata[1];

  assign busy   = st != S_IDLE;
  assign mem_rd = busy;
  assign mem_addr = (st == S_TBL)
    ? {tbase, {OFF_W{1'b0}}} + {{(32-IDX_W-2){1'b0}}, va[OFF_W+IDX_W-1:OFF_W], 2'b00}
    : dir_base + {{(32-IDX_W-2){1'b0}}, va[31:32-IDX_W], 2'b00};

  always_comb begin
    fin  = 1'b0;
    kind = K_OK;
    if (hit) begin
      if (mem_rerr) begin
        fin = 1'b1; kind = K_BUS;
      end else if (!mem_rdata[0]) begin
        fin = 1'b1; kind = K_PF;
      end else if (st == S_TBL) begin
        fin = 1'b1; kind = perm_ok ? K_OK : K_PF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va        <= '0;
      wr        <= 1'b0;
      tbase     <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= K_OK;
      rsp_vaddr <= '0;
      rsp_write <= 1'b0;
      rsp_paddr <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          va <= req_vaddr;
          wr <= req_write;
          st <= S_DIR;
        end
      end else if (fin) begin
        st        <= S_IDLE;
        rsp_valid <= 1'b1;
        rsp_kind  <= kind;
        rsp_vaddr <= va;
        rsp_write <= wr;
        rsp_paddr <= (kind == K_OK) ? {mem_rdata[31:OFF_W], va[OFF_W-1:0]} : '0;
        rsp_attr  <= (kind == K_OK) ? mem_rdata[8:1] : '0;
      end else if (hit) begin
        tbase <= mem_rdata[31:OFF_W];
        st    <= S_TBL;
      end
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] dir_base,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        busy,
  input logic        mem_rd,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        rsp_valid,
  input logic [1:0]  rsp_kind,
  input logic [31:0] rsp_vaddr,
  input logic [31:0] rsp_paddr
);
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
  // R10
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_rvalid |=> mem_rd && $stable(mem_addr));
  // R1
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_addr == dir_base + {20'h0, $past(req_vaddr[31:22]), 2'b00});
  // R5
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd0 |-> rsp_paddr[11:0] == rsp_vaddr[11:0]);
  // R11
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R11
  kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_kind != 2'd3);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_base(dir_base), .req_valid(req_valid),
  .req_vaddr(req_vaddr), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
  .rsp_vaddr(rsp_vaddr), .rsp_paddr(rsp_paddr)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] dir_base = 32'h0010_0000;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = 0;
  logic busy, mem_rd, rsp_valid, rsp_write;
  logic [31:0] mem_addr, rsp_vaddr, rsp_paddr;
  logic mem_rvalid = 0, mem_rerr = 0;
  logic [31:0] mem_rdata = 0;
  logic [1:0] rsp_kind;
  logic [7:0] rsp_attr;

  always #10 clk = ~clk;

  pt_walker uut (.*);

  int checks = 0, fails = 0, lat = 0, cnt = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  bit berr [logic [31:0]];
  logic [31:0] rd_log [$];

  typedef struct {
    logic [1:0] kind; logic [31:0] va; logic w;
    logic [31:0] pa; logic [7:0] attr;
    logic [31:0] a0, a1; int nrd;
  } exp_t;
  exp_t sb [$];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic exp_t model(input logic [31:0] va, input logic w);
    exp_t e;
    logic [31:0] d, p;
    e.va = va; e.w = w; e.pa = 0; e.attr = 0; e.a1 = 0;
    e.a0 = dir_base + {20'h0, va[31:22], 2'b00};
    d = rdm(e.a0); e.nrd = 1;
    if (berr.exists(e.a0)) begin e.kind = 2; return e; end
    if (!d[0]) begin e.kind = 1; return e; end
    e.a1 = {d[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
    p = rdm(e.a1); e.nrd = 2;
    if (berr.exists(e.a1)) begin e.kind = 2; return e; end
    if (!p[0] || !(w ? p[2] : p[1])) begin e.kind = 1; return e; end
    e.kind = 0; e.pa = {p[31:12], va[11:0]}; e.attr = p[8:1];
    return e;
  endfunction

  // memory responder
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 0; cnt = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 0; mem_rerr = 0; cnt = 0;
    end else if (mem_rd) begin
      if (cnt >= lat) begin
        mem_rvalid = 1;
        mem_rdata = rdm(mem_addr);
        mem_rerr = berr.exists(mem_addr);
        rd_log.push_back(mem_addr);
      end else cnt++;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) chk(0, "R9 unexpected result", {30'h0, rsp_kind}, 64'hF);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_kind == e.kind, "R3/R4/R6/R7 kind", {62'h0, rsp_kind}, {62'h0, e.kind});
        chk(rsp_vaddr == e.va && rsp_write == e.w, "R8 vaddr/dir", {rsp_write, rsp_vaddr}, {e.w, e.va});
        if (e.kind == 0) begin
          chk(rsp_paddr == e.pa, "R5 paddr", {32'h0, rsp_paddr}, {32'h0, e.pa});
          chk(rsp_attr == e.attr, "R5 attr", {56'h0, rsp_attr}, {56'h0, e.attr});
        end
        chk(rd_log.size() == e.nrd, "R3/R7 read count", rd_log.size(), e.nrd);
        if (rd_log.size() > 0) chk(rd_log[0] == e.a0, "R1 dir addr", {32'h0, rd_log[0]}, {32'h0, e.a0});
        if (rd_log.size() > 1 && e.nrd == 2) chk(rd_log[1] == e.a1, "R2 table addr", {32'h0, rd_log[1]}, {32'h0, e.a1});
        rd_log.delete();
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic w, input int noise_at);
    sb.push_back(model(va, w));
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = w;
    @(negedge clk);
    req_valid = 0;
    if (noise_at > 0) begin
      repeat (noise_at) @(negedge clk);
      req_valid = 1; req_vaddr = 32'hFFFF_F000; req_write = ~w;
      @(negedge clk);
      chk(busy == 1, "R9 busy during walk", {63'h0, busy}, 64'h1);
      @(negedge clk);
      req_valid = 0;
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(rsp_valid == 0, "R11 single pulse", {63'h0, rsp_valid}, 64'h0);
    chk(busy == 0, "R9 idle after result", {63'h0, busy}, 64'h0);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    mem[32'h0010_0004] = 32'h0020_0FFF;   // dir 1 -> table 0x00200000, junk low bits (R2)
    mem[32'h0020_000C] = 32'hABCD_E1F7;   // rw, attrs set
    mem[32'h0020_0010] = 32'h1234_5003;   // read-only
    mem[32'h0020_0014] = 32'h5555_5005;   // write-only
    mem[32'h0020_0018] = 32'h7777_7006;   // not valid
    mem[32'h0020_001C] = 32'h9999_9007; berr[32'h0020_001C] = 1;
    mem[32'h0010_0008] = 32'h0030_0000;   // dir 2 invalid
    mem[32'h0010_000C] = 32'h0040_0001; berr[32'h0010_000C] = 1;

    repeat (3) @(negedge clk);
    chk(busy == 0 && rsp_valid == 0 && mem_rd == 0, "R9/R11 reset state",
        {61'h0, busy, rsp_valid, mem_rd}, 64'h0);
    rst_n = 1;
    @(negedge clk);

    for (int l = 0; l < 4; l++) begin
      lat = l;
      walk(32'h0040_3ABC, 0, 0);            // R5 read, varied latency (R10)
    end
    lat = 1;
    walk(32'h0040_3123, 1, 0);              // R5 write ok
    walk(32'h0040_4FFF, 0, 0);              // R6 read on read-only ok
    walk(32'h0040_4000, 1, 0);              // R6 write on read-only -> pf
    walk(32'h0040_5010, 0, 0);              // R6 read on write-only -> pf
    walk(32'h0040_5010, 1, 0);              // R6 write on write-only ok
    walk(32'h0040_6000, 0, 0);              // R4 pte invalid
    walk(32'h0080_0ABC, 1, 0);              // R3 dte invalid
    walk(32'h0040_7000, 0, 0);              // R7 level-2 bus error
    walk(32'h00C0_0000, 1, 0);              // R7 level-1 bus error
    walk(32'hFFC0_0000, 0, 0);              // R3 unmapped directory
    lat = 3;
    walk(32'h0040_3ABC, 1, 2);              // R9 request during walk ignored
    repeat (4) @(negedge clk);
    chk(busy == 0 && sb.size() == 0, "R9 no extra walk", {63'h0, busy}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule